// File: doc/BRIEF.md
# Set-Associative Address Translation Cache with Access Protection

This block maps a 40-bit virtual address onto a 36-bit physical address through a small translation cache. The cache has two ways and 256 sets. Pages are 16 KB, so the low 14 address bits pass straight through as the page offset. The 26-bit virtual page number divides into two parts. Its low 8 bits pick a set. Its upper 18 bits are compared against the tag stored in each way of that set.

Every lookup states its access kind: read, write or execute. The kind is checked against the rights field of the entry that matched. A lookup that finds no entry raises a miss. The miss is a trap for software, and no table walk happens in hardware. Software loads entries through a refill port and clears the reference bits in bulk. It can inspect any entry through a combinational read port.

Each entry also keeps a dirty bit and a reference bit. A permitted write to a clean page marks the page dirty and pulses a flag so that software can copy the change into its own tables. Each set keeps one LRU bit. That bit is offered as the suggested way to overwrite when software refills the set.

Top module: `tlb_xlate`

## Requirements
- R1: A hit produces `lk_paddr` = {stored page frame, `lk_vaddr[13:0]`}. When there is no hit, `lk_paddr` is zero. The set index is `lk_vaddr[21:14]` and the tag is `lk_vaddr[39:22]`.
- R2: When `lk_valid` is high, `lk_hit` is high if some way of the indexed set is valid and holds the matching tag. Otherwise `lk_miss` is high. When `lk_valid` is low, both flags are low and no entry state changes.
- R3: The rights code is 0 for no access, 1 for read-only, 2 for read/write and 3 for execute-only. The access code is 0 for read, 1 for write and 2 for execute; code 3 is never permitted. A read is permitted with rights 1 or 2. A write is permitted only with rights 2. An execute is permitted only with rights 3. A hit whose access is not permitted raises `lk_fault`.
- R4: A faulting access changes neither the dirty bit nor the reference bit of its entry.
- R5: A permitted write that hits a clean entry raises `lk_dirty_set` in the same cycle, and the entry's dirty bit reads 1 after the next clock edge. A write that hits an entry already dirty does not raise the flag, and neither does a read.
- R6: A permitted hit sets the entry's reference bit at the next edge. `ref_clr` clears every reference bit at the next edge. If both happen in the same cycle, the hit entry ends with its reference bit set.
- R7: A refill writes valid, dirty, rights, tag and frame at the next edge and clears the reference bit. A lookup in the same cycle still sees the old contents. When a refill and a lookup update target the same entry, the refill wins.
- R8: `lk_victim_way` gives the LRU bit of the indexed set. After any hit, including a faulting one, the bit names the way that was not hit. Refills leave it unchanged.
- R9: After reset, every entry is invalid with all fields zero, and every LRU bit is 0.
- R10: If both ways of a set match, way 0 supplies the translation, and `lk_hit_way` reports 0.
- R11: The read port returns the fields of the entry selected by `rd_set` and `rd_way` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 40 | Virtual address |
| lk_acc | input | 2 | Access kind (0 read, 1 write, 2 execute) |
| lk_paddr | output | 36 | Physical address |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | Trap: no translation |
| lk_fault | output | 1 | Protection fault |
| lk_dirty_set | output | 1 | Clean page being marked dirty |
| lk_hit_way | output | 1 | Way that hit |
| lk_victim_way | output | 1 | Suggested refill way for the indexed set |
| rf_we | input | 1 | Refill write enable |
| rf_set | input | 8 | Refill set |
| rf_way | input | 1 | Refill way |
| rf_valid | input | 1 | Refill valid bit |
| rf_dirty | input | 1 | Refill dirty bit |
| rf_rights | input | 2 | Refill rights code |
| rf_tag | input | 18 | Refill tag |
| rf_ppn | input | 22 | Refill page frame |
| ref_clr | input | 1 | Clear all reference bits |
| rd_set | input | 8 | Read port set |
| rd_way | input | 1 | Read port way |
| rd_valid | output | 1 | Read valid bit |
| rd_dirty | output | 1 | Read dirty bit |
| rd_ref | output | 1 | Read reference bit |
| rd_rights | output | 2 | Read rights code |
| rd_tag | output | 18 | Read tag |
| rd_ppn | output | 22 | Read page frame |

## Verification
The hardest situations to reach from the ports are the same-cycle collisions. In one, a refill lands on the very entry that a lookup is reading. In the other, a bulk reference clear arrives in the same cycle as a hit that sets a reference bit. The bench drives both events in a single cycle. For the refill case, it uses an entry that was invalid just before. In that cycle the old contents show up as a miss, and after the edge a hit confirms the new contents. Faults are shown to leave no trace by reading the entry back through the read port right after the faulting access.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_EXEC  = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_e;

   localparam logic [1:0] RIGHTS_NONE = 2'd0;
   localparam logic [1:0] RIGHTS_RO   = 2'd1;
   localparam logic [1:0] RIGHTS_RW   = 2'd2;
   localparam logic [1:0] RIGHTS_XO   = 2'd3;
endpackage

// File: rtl/tlb_perm.sv
module tlb_perm
   import tlb_pkg::*;
(
   input  logic [1:0] rights,
   input  logic [1:0] acc,
   output logic       ok
);
   always_comb begin
      ok = 1'b0;
      case (rights)
         RIGHTS_RO: ok = (acc == ACC_READ);
         RIGHTS_RW: ok = (acc == ACC_READ) || (acc == ACC_WRITE);
         RIGHTS_XO: ok = (acc == ACC_EXEC);
         default:   ok = 1'b0;
      endcase
   end
endmodule

// File: rtl/tlb_way_store.sv
module tlb_way_store #(
   parameter int TAG_W = 18,
   parameter int PPN_W = 22,
   parameter int SET_W = 8,
   localparam int SETS = 1 << SET_W
) (
   input  logic             clk,
   input  logic             rst_n,
   // lookup read and update
   input  logic [SET_W-1:0] lk_set,
   output logic             lk_v,
   output logic             lk_d,
   output logic [1:0]       lk_rights,
   output logic [TAG_W-1:0] lk_tag,
   output logic [PPN_W-1:0] lk_ppn,
   input  logic             use_en,
   input  logic             mark_dirty,
   // bulk reference clear
   input  logic             ref_clr,
   // refill
   input  logic             wr_en,
   input  logic [SET_W-1:0] wr_set,
   input  logic             wr_v,
   input  logic             wr_d,
   input  logic [1:0]       wr_rights,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic [PPN_W-1:0] wr_ppn,
   // inspection
   input  logic [SET_W-1:0] rd_set,
   output logic             rd_v,
   output logic             rd_d,
   output logic             rd_r,
   output logic [1:0]       rd_rights,
   output logic [TAG_W-1:0] rd_tag,
   output logic [PPN_W-1:0] rd_ppn
);
   logic             v_q      [SETS];
   logic             d_q      [SETS];
   logic             r_q      [SETS];
   logic [1:0]       rights_q [SETS];
   logic [TAG_W-1:0] tag_q    [SETS];
   logic [PPN_W-1:0] ppn_q    [SETS];

   // Later assignments take priority: clear < use < refill.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            v_q[s]      <= 1'b0;
            d_q[s]      <= 1'b0;
            r_q[s]      <= 1'b0;
            rights_q[s] <= '0;
            tag_q[s]    <= '0;
            ppn_q[s]    <= '0;
         end
      end else begin
         if (ref_clr) begin
            for (int s = 0; s < SETS; s++) r_q[s] <= 1'b0;
         end
         if (use_en)     r_q[lk_set] <= 1'b1;
         if (mark_dirty) d_q[lk_set] <= 1'b1;
         if (wr_en) begin
            v_q[wr_set]      <= wr_v;
            d_q[wr_set]      <= wr_d;
            r_q[wr_set]      <= 1'b0;
            rights_q[wr_set] <= wr_rights;
            tag_q[wr_set]    <= wr_tag;
            ppn_q[wr_set]    <= wr_ppn;
         end
      end
   end

   assign lk_v      = v_q[lk_set];
   assign lk_d      = d_q[lk_set];
   assign lk_rights = rights_q[lk_set];
   assign lk_tag    = tag_q[lk_set];
   assign lk_ppn    = ppn_q[lk_set];

   assign rd_v      = v_q[rd_set];
   assign rd_d      = d_q[rd_set];
   assign rd_r      = r_q[rd_set];
   assign rd_rights = rights_q[rd_set];
   assign rd_tag    = tag_q[rd_set];
   assign rd_ppn    = ppn_q[rd_set];
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
   parameter int SET_W = 8,
   localparam int SETS = 1 << SET_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             upd_en,
   input  logic [SET_W-1:0] upd_set,
   input  logic             used_way,
   input  logic [SET_W-1:0] q_set,
   output logic             victim
);
   logic lru_q [SETS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) lru_q[s] <= 1'b0;
      end else if (upd_en) begin
         lru_q[upd_set] <= ~used_way;
      end
   end

   assign victim = lru_q[q_set];
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
   import tlb_pkg::*;
#(
   parameter int VA_W   = 40,
   parameter int PA_W   = 36,
   parameter int PAGE_W = 14,
   parameter int SET_W  = 8,
   parameter int WAYS   = 2,
   localparam int TAG_W = VA_W - PAGE_W - SET_W,
   localparam int PPN_W = PA_W - PAGE_W,
   localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lk_valid,
   input  logic [VA_W-1:0]  lk_vaddr,
   input  logic [1:0]       lk_acc,
   output logic [PA_W-1:0]  lk_paddr,
   output logic             lk_hit,
   output logic             lk_miss,
   output logic             lk_fault,
   output logic             lk_dirty_set,
   output logic [WAY_W-1:0] lk_hit_way,
   output logic [WAY_W-1:0] lk_victim_way,
   input  logic             rf_we,
   input  logic [SET_W-1:0] rf_set,
   input  logic [WAY_W-1:0] rf_way,
   input  logic             rf_valid,
   input  logic             rf_dirty,
   input  logic [1:0]       rf_rights,
   input  logic [TAG_W-1:0] rf_tag,
   input  logic [PPN_W-1:0] rf_ppn,
   input  logic             ref_clr,
   input  logic [SET_W-1:0] rd_set,
   input  logic [WAY_W-1:0] rd_way,
   output logic             rd_valid,
   output logic             rd_dirty,
   output logic             rd_ref,
   output logic [1:0]       rd_rights,
   output logic [TAG_W-1:0] rd_tag,
   output logic [PPN_W-1:0] rd_ppn
);
   // elaboration-time parameter checks
   generate
      if (WAYS != 2) begin : g_bad_ways
         $error("tlb_xlate: single LRU bit per set needs exactly two ways");
      end
      if (TAG_W < 1) begin : g_bad_tag
         $error("tlb_xlate: page and set bits exceed the virtual address");
      end
      if (PPN_W < 1) begin : g_bad_ppn
         $error("tlb_xlate: page offset exceeds the physical address");
      end
   endgenerate

   logic [SET_W-1:0]  va_set;
   logic [TAG_W-1:0]  va_tag;
   logic [PAGE_W-1:0] va_off;
   assign va_off = lk_vaddr[PAGE_W-1:0];
   assign va_set = lk_vaddr[PAGE_W +: SET_W];
   assign va_tag = lk_vaddr[VA_W-1 -: TAG_W];

   logic [WAYS-1:0]  w_v, w_d, w_r, match, use_en, mark_dirty, wr_en;
   logic [1:0]       w_rights [WAYS];
   logic [TAG_W-1:0] w_tag    [WAYS];
   logic [PPN_W-1:0] w_ppn    [WAYS];
   logic [1:0]       r_rights [WAYS];
   logic [TAG_W-1:0] r_tag    [WAYS];
   logic [PPN_W-1:0] r_ppn    [WAYS];
   logic [WAYS-1:0]  r_v, r_d;

   logic             any_hit, perm_ok, access_ok;
   logic [WAY_W-1:0] sel_way;
   logic [1:0]       sel_rights;
   logic [PPN_W-1:0] sel_ppn;
   logic             sel_dirty;

   generate
      for (genvar w = 0; w < WAYS; w++) begin : g_way
         assign match[w]      = lk_valid && w_v[w] && (w_tag[w] == va_tag);
         assign wr_en[w]      = rf_we && (rf_way == WAY_W'(w));
         assign use_en[w]     = access_ok && (sel_way == WAY_W'(w));
         assign mark_dirty[w] = use_en[w] && (lk_acc == ACC_WRITE) && !w_d[w];

         tlb_way_store #(
            .TAG_W(TAG_W), .PPN_W(PPN_W), .SET_W(SET_W)
         ) u_store (
            .clk        (clk),
            .rst_n      (rst_n),
            .lk_set     (va_set),
            .lk_v       (w_v[w]),
            .lk_d       (w_d[w]),
            .lk_rights  (w_rights[w]),
            .lk_tag     (w_tag[w]),
            .lk_ppn     (w_ppn[w]),
            .use_en     (use_en[w]),
            .mark_dirty (mark_dirty[w]),
            .ref_clr    (ref_clr),
            .wr_en      (wr_en[w]),
            .wr_set     (rf_set),
            .wr_v       (rf_valid),
            .wr_d       (rf_dirty),
            .wr_rights  (rf_rights),
            .wr_tag     (rf_tag),
            .wr_ppn     (rf_ppn),
            .rd_set     (rd_set),
            .rd_v       (r_v[w]),
            .rd_d       (r_d[w]),
            .rd_r       (w_r[w]),
            .rd_rights  (r_rights[w]),
            .rd_tag     (r_tag[w]),
            .rd_ppn     (r_ppn[w])
         );
      end
   endgenerate

   // lowest-numbered matching way wins
   always_comb begin
      sel_way = '0;
      any_hit = 1'b0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (match[w]) begin
            sel_way = WAY_W'(w);
            any_hit = 1'b1;
         end
      end
   end

   assign sel_rights = w_rights[sel_way];
   assign sel_ppn    = w_ppn[sel_way];
   assign sel_dirty  = w_d[sel_way];

   tlb_perm u_perm (
      .rights (sel_rights),
      .acc    (lk_acc),
      .ok     (perm_ok)
   );

   assign access_ok = any_hit && perm_ok;

   tlb_lru #(.SET_W(SET_W)) u_lru (
      .clk      (clk),
      .rst_n    (rst_n),
      .upd_en   (any_hit),
      .upd_set  (va_set),
      .used_way (sel_way[0]),
      .q_set    (va_set),
      .victim   (lk_victim_way[0])
   );

   assign lk_hit       = any_hit;
   assign lk_miss      = lk_valid && !any_hit;
   assign lk_fault     = any_hit && !perm_ok;
   assign lk_dirty_set = access_ok && (lk_acc == ACC_WRITE) && !sel_dirty;
   assign lk_hit_way   = sel_way;
   assign lk_paddr     = any_hit ? {sel_ppn, va_off} : '0;

   assign rd_valid  = r_v[rd_way];
   assign rd_dirty  = r_d[rd_way];
   assign rd_ref    = w_r[rd_way];
   assign rd_rights = r_rights[rd_way];
   assign rd_tag    = r_tag[rd_way];
   assign rd_ppn    = r_ppn[rd_way];
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
   parameter int PAGE_W = 14,
   parameter int SET_W  = 8,
   parameter int WAY_W  = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lk_valid,
   input logic [1:0]        lk_acc,
   input logic [PAGE_W-1:0] lk_off,
   input logic [SET_W-1:0]  lk_set,
   input logic [PAGE_W-1:0] pa_off,
   input logic              lk_hit,
   input logic              lk_miss,
   input logic              lk_fault,
   input logic              lk_dirty_set,
   input logic [WAY_W-1:0]  lk_hit_way,
   input logic [WAY_W-1:0]  lk_victim_way
);
   AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(lk_hit && lk_miss));                                           // R2
   AST_HIT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> lk_valid);                                            // R2
   AST_MISS_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      lk_miss |-> lk_valid);                                           // R2
   AST_FAULT_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      lk_fault |-> lk_hit);                                            // R3
   AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> (pa_off == lk_off));                                  // R1
   AST_DIRTY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      lk_dirty_set |-> (lk_hit && !lk_fault && lk_acc == 2'd1));       // R5
   AST_VICTIM_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |=> (lk_set != $past(lk_set) || lk_victim_way != $past(lk_hit_way))); // R8
endmodule

bind tlb_xlate tlb_xlate_chk #(
   .PAGE_W (PAGE_W),
   .SET_W  (SET_W),
   .WAY_W  (WAY_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .lk_valid      (lk_valid),
   .lk_acc        (lk_acc),
   .lk_off        (lk_vaddr[PAGE_W-1:0]),
   .lk_set        (lk_vaddr[PAGE_W +: SET_W]),
   .pa_off        (lk_paddr[PAGE_W-1:0]),
   .lk_hit        (lk_hit),
   .lk_miss       (lk_miss),
   .lk_fault      (lk_fault),
   .lk_dirty_set  (lk_dirty_set),
   .lk_hit_way    (lk_hit_way),
   .lk_victim_way (lk_victim_way)
);

// File: tb/tlb_xlate_tb_top.sv
module tlb_xlate_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_valid = 1'b0;
   logic [39:0] lk_vaddr = '0;
   logic [1:0]  lk_acc = '0;
   logic [35:0] lk_paddr;
   logic        lk_hit, lk_miss, lk_fault, lk_dirty_set;
   logic [0:0]  lk_hit_way, lk_victim_way;
   logic        rf_we = 1'b0;
   logic [7:0]  rf_set = '0;
   logic [0:0]  rf_way = '0;
   logic        rf_valid = 1'b0, rf_dirty = 1'b0;
   logic [1:0]  rf_rights = '0;
   logic [17:0] rf_tag = '0;
   logic [21:0] rf_ppn = '0;
   logic        ref_clr = 1'b0;
   logic [7:0]  rd_set = '0;
   logic [0:0]  rd_way = '0;
   logic        rd_valid, rd_dirty, rd_ref;
   logic [1:0]  rd_rights;
   logic [17:0] rd_tag;
   logic [21:0] rd_ppn;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   tlb_xlate dut_i (
      .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
      .lk_acc(lk_acc), .lk_paddr(lk_paddr), .lk_hit(lk_hit), .lk_miss(lk_miss),
      .lk_fault(lk_fault), .lk_dirty_set(lk_dirty_set), .lk_hit_way(lk_hit_way),
      .lk_victim_way(lk_victim_way), .rf_we(rf_we), .rf_set(rf_set),
      .rf_way(rf_way), .rf_valid(rf_valid), .rf_dirty(rf_dirty),
      .rf_rights(rf_rights), .rf_tag(rf_tag), .rf_ppn(rf_ppn),
      .ref_clr(ref_clr), .rd_set(rd_set), .rd_way(rd_way),
      .rd_valid(rd_valid), .rd_dirty(rd_dirty), .rd_ref(rd_ref),
      .rd_rights(rd_rights), .rd_tag(rd_tag), .rd_ppn(rd_ppn)
   );

   function automatic logic [39:0] mkva(logic [17:0] t, logic [7:0] s, logic [13:0] o);
      return {t, s, o};
   endfunction

   function automatic bit exp_ok(logic [1:0] r, logic [1:0] a);
      case (r)
         2'd1: return a == 2'd0;
         2'd2: return (a == 2'd0) || (a == 2'd1);
         2'd3: return a == 2'd2;
         default: return 1'b0;
      endcase
   endfunction

   task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // each step task occupies exactly one clock edge
   task automatic quiet_drive();
      @(negedge clk);
      lk_valid = 1'b0; rf_we = 1'b0; ref_clr = 1'b0;
   endtask

   task automatic refill(logic [7:0] s, logic w, logic [17:0] t, logic [21:0] p,
                         logic [1:0] r, logic d);
      quiet_drive();
      rf_we = 1'b1; rf_set = s; rf_way = w; rf_valid = 1'b1;
      rf_dirty = d; rf_rights = r; rf_tag = t; rf_ppn = p;
   endtask

   task automatic lookup(logic [39:0] va, logic [1:0] a);
      quiet_drive();
      lk_valid = 1'b1; lk_vaddr = va; lk_acc = a;
      #2;
   endtask

   task automatic peek(logic [7:0] s, logic w);
      quiet_drive();
      rd_set = s; rd_way = w;
      #2;
   endtask

   task automatic t_reset();
      lookup(mkva(18'h1, 8'h3, 14'h5), 2'd0);
      check("R9", "miss after reset", lk_miss, 1);
      check("R9", "hit after reset", lk_hit, 0);
      check("R9", "victim after reset", lk_victim_way, 0);
      peek(8'h3, 1'b1);
      check("R9", "valid after reset", rd_valid, 0);
   endtask

   task automatic t_basic();
      refill(8'h05, 1'b0, 18'h2ABCD, 22'h155AA, 2'd2, 1'b0);
      lookup(mkva(18'h2ABCD, 8'h05, 14'h1234), 2'd0);
      check("R2", "hit", lk_hit, 1);
      check("R1", "paddr", lk_paddr, {22'h155AA, 14'h1234});
      lookup(mkva(18'h2ABCD, 8'h05, 14'h3FFF), 2'd0);
      check("R1", "paddr top offset", lk_paddr, {22'h155AA, 14'h3FFF});
      lookup(mkva(18'h2ABCE, 8'h05, 14'h0), 2'd0);
      check("R2", "tag mismatch miss", lk_miss, 1);
      check("R1", "paddr zero on miss", lk_paddr, 0);
      lookup(mkva(18'h2ABCD, 8'h06, 14'h0), 2'd0);
      check("R2", "other set miss", lk_miss, 1);
      peek(8'h05, 1'b0);
      check("R11", "read tag", rd_tag, 18'h2ABCD);
      check("R11", "read ppn", rd_ppn, 22'h155AA);
      check("R11", "read rights", rd_rights, 2'd2);
   endtask

   task automatic t_idle_no_effect();
      refill(8'h07, 1'b0, 18'h7, 22'h7, 2'd2, 1'b0);
      quiet_drive();
      lk_vaddr = mkva(18'h7, 8'h07, 14'h0); lk_acc = 2'd1;
      #2;
      check("R2", "no hit when idle", lk_hit, 0);
      check("R2", "no miss when idle", lk_miss, 0);
      peek(8'h07, 1'b0);
      check("R2", "idle leaves ref", rd_ref, 0);
      check("R2", "idle leaves dirty", rd_dirty, 0);
   endtask

   task automatic t_perm();
      for (int r = 0; r < 4; r++) begin
         refill(8'h20, 1'b0, 18'h100, 22'h3, 2'(r), 1'b0);
         for (int a = 0; a < 4; a++) begin
            lookup(mkva(18'h100, 8'h20, 14'h0), 2'(a));
            check("R3", $sformatf("fault rights %0d acc %0d", r, a),
                  lk_fault, !exp_ok(2'(r), 2'(a)));
         end
      end
   endtask

   task automatic t_fault_no_trace();
      refill(8'h21, 1'b1, 18'h55, 22'h9, 2'd1, 1'b0);
      lookup(mkva(18'h55, 8'h21, 14'h0), 2'd1);
      check("R4", "write to read-only faults", lk_fault, 1);
      check("R4", "no dirty flag on fault", lk_dirty_set, 0);
      peek(8'h21, 1'b1);
      check("R4", "dirty untouched", rd_dirty, 0);
      check("R4", "ref untouched", rd_ref, 0);
   endtask

   task automatic t_dirty();
      refill(8'h30, 1'b0, 18'hAA, 22'h11, 2'd2, 1'b0);
      lookup(mkva(18'hAA, 8'h30, 14'h0), 2'd0);
      check("R5", "read gives no dirty flag", lk_dirty_set, 0);
      lookup(mkva(18'hAA, 8'h30, 14'h0), 2'd1);
      check("R5", "first write flags", lk_dirty_set, 1);
      peek(8'h30, 1'b0);
      check("R5", "dirty stored", rd_dirty, 1);
      lookup(mkva(18'hAA, 8'h30, 14'h0), 2'd1);
      check("R5", "second write silent", lk_dirty_set, 0);
   endtask

   task automatic t_ref();
      refill(8'h40, 1'b0, 18'hBB, 22'h22, 2'd2, 1'b0);
      lookup(mkva(18'hBB, 8'h40, 14'h0), 2'd0);
      peek(8'h40, 1'b0);
      check("R6", "ref set by hit", rd_ref, 1);
      quiet_drive(); ref_clr = 1'b1;
      peek(8'h40, 1'b0);
      check("R6", "ref cleared", rd_ref, 0);
      lookup(mkva(18'hBB, 8'h40, 14'h0), 2'd0);
      ref_clr = 1'b1;
      peek(8'h40, 1'b0);
      check("R6", "hit beats clear", rd_ref, 1);
      refill(8'h40, 1'b0, 18'hBB, 22'h23, 2'd2, 1'b0);
      peek(8'h40, 1'b0);
      check("R7", "refill clears ref", rd_ref, 0);
   endtask

   task automatic t_collide();
      quiet_drive();
      rf_we = 1'b1; rf_set = 8'h50; rf_way = 1'b1; rf_valid = 1'b1;
      rf_dirty = 1'b0; rf_rights = 2'd2; rf_tag = 18'hCC; rf_ppn = 22'h33;
      lk_valid = 1'b1; lk_vaddr = mkva(18'hCC, 8'h50, 14'h10); lk_acc = 2'd0;
      #2;
      check("R7", "same-cycle lookup sees old entry", lk_miss, 1);
      lookup(mkva(18'hCC, 8'h50, 14'h10), 2'd0);
      check("R7", "hit after refill edge", lk_hit, 1);
      check("R7", "paddr after refill", lk_paddr, {22'h33, 14'h10});
      // refill wins over a dirty update to the same entry
      lookup(mkva(18'hCC, 8'h50, 14'h0), 2'd1);
      rf_we = 1'b1; rf_set = 8'h50; rf_way = 1'b1; rf_dirty = 1'b0; rf_ppn = 22'h34;
      peek(8'h50, 1'b1);
      check("R7", "refill beats dirty update", rd_dirty, 0);
      check("R7", "refill frame", rd_ppn, 22'h34);
   endtask

   task automatic t_lru();
      refill(8'h60, 1'b0, 18'h1, 22'h1, 2'd2, 1'b0);
      refill(8'h60, 1'b1, 18'h2, 22'h2, 2'd2, 1'b0);
      lookup(mkva(18'h1, 8'h60, 14'h0), 2'd0);
      check("R8", "victim before hits", lk_victim_way, 0);
      lookup(mkva(18'h1, 8'h60, 14'h0), 2'd0);
      check("R8", "victim after way0 hit", lk_victim_way, 1);
      lookup(mkva(18'h2, 8'h60, 14'h0), 2'd2);
      check("R8", "hit way 1", lk_hit_way, 1);
      lookup(mkva(18'h2, 8'h60, 14'h0), 2'd0);
      check("R8", "victim after faulting way1 hit", lk_victim_way, 0);
      refill(8'h60, 1'b0, 18'h9, 22'h9, 2'd2, 1'b0);
      lookup(mkva(18'h7, 8'h60, 14'h0), 2'd0);
      check("R8", "refill keeps victim", lk_victim_way, 0);
   endtask

   task automatic t_dup();
      refill(8'h70, 1'b0, 18'h44, 22'h100, 2'd2, 1'b0);
      refill(8'h70, 1'b1, 18'h44, 22'h200, 2'd2, 1'b0);
      lookup(mkva(18'h44, 8'h70, 14'h8), 2'd0);
      check("R10", "dup hit way", lk_hit_way, 0);
      check("R10", "dup frame", lk_paddr, {22'h100, 14'h8});
   endtask

   initial begin
      #(20 * 100000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_basic();
      t_idle_no_effect();
      t_perm();
      t_fault_no_trace();
      t_dirty();
      t_ref();
      t_collide();
      t_lru();
      t_dup();
      quiet_drive();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule